// File: doc/BRIEF.md
# Write Command and Data Scheduler for a Low-Latency DRAM

This block sits between a local write port and the command and data pins of a DRAM with a fixed write latency. A local write request, carrying a bank and an address, is turned into a write command on the memory side in the same cycle it is accepted. The data for that write is not taken with the request. The block asks for it later through its own strobe, one local word per cycle. The strobe is timed so that the first word reaches the memory data bus exactly the write latency after the command.

Each local word carries several memory beats, so a burst needs burst length divided by beats per word data cycles. Several writes can be in flight at once. Their data requests come out in command order. A ready signal refuses a request that would reuse a bank before its row cycle time has elapsed, and also a request whose data phase would overlap the previous write's data phase.

Top module: `wr_sched`

## Requirements
- R1: When wr_req_i and wr_rdy_o are both high in a cycle, mem_cmd_o is 2'b01 (write) in that same cycle, and mem_bank_o and mem_addr_o equal wr_bank_i and wr_addr_i. In every other cycle mem_cmd_o is 2'b00 (no operation).
- R2: For each accepted write, wdata_req_o is high for NWORDS = BURST_LEN/BEATS_PER_WORD consecutive cycles. The first of these cycles is TWL-2 cycles after the accept cycle.
- R3: The word on wdata_i in the cycle after a wdata_req_o cycle appears on mem_dq_o one cycle later, with mem_dv_o high. The first data cycle of a write is exactly TWL cycles after its command cycle.
- R4: mem_dv_o is high for exactly NWORDS cycles per accepted write. mem_dq_o is all zero whenever mem_dv_o is low.
- R5: After a write to a bank is accepted, wr_rdy_o stays low for a request to that same bank for the next TRC-1 cycles. A request to that bank is accepted again TRC cycles after the first accept.
- R6: After any accepted write, wr_rdy_o stays low for the next NWORDS-1 cycles whatever the bank. A request to another bank that is free is accepted NWORDS cycles after the previous accept.
- R7: When several writes are in flight, their data-request windows and data cycles follow the order of their commands. Each data cycle carries the word requested for its own write.
- R8: While rst_n is low, wr_rdy_o, wdata_req_o and mem_dv_o are low, mem_dq_o is zero and mem_cmd_o is 2'b00. In the first cycle after release wr_rdy_o is high.
- R9: A request made while wr_rdy_o is low produces no command and no later data request or data cycle. A request held high is accepted in the first cycle that ready allows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_req_i | input | 1 | Local write request |
| wr_bank_i | input | BANK_W | Bank of the request |
| wr_addr_i | input | ADDR_W | Address of the request |
| wdata_i | input | DATA_W | Local write word, valid the cycle after wdata_req_o |
| wr_rdy_o | output | 1 | Request is accepted this cycle if wr_req_i is high |
| mem_cmd_o | output | 2 | Memory command: 00 no operation, 01 write |
| mem_bank_o | output | BANK_W | Memory bank of the command |
| mem_addr_o | output | ADDR_W | Memory address of the command |
| wdata_req_o | output | 1 | Request for one local write word |
| mem_dq_o | output | DATA_W | Memory write data, BEATS_PER_WORD beats per cycle |
| mem_dv_o | output | 1 | mem_dq_o carries write data |

## Verification
The command and ready outputs are due in the same cycle as the request, so the bench drives the request just after a rising edge and reads them at the next falling edge. A write accepted in cycle a must show its data strobe in cycles a+TWL-2 through a+TWL+NWORDS-3. The word the bench supplies one cycle after each strobe must appear on the memory bus in cycles a+TWL through a+TWL+NWORDS-1. The bench keeps a list of its own predicted accept cycles and derives, for every cycle, which write owns the strobe and which owns the bus. It compares all outputs against that in every cycle rather than only at chosen points.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

   typedef enum logic [1:0] {
      CMD_NOP   = 2'b00,
      CMD_WRITE = 2'b01
   } mem_cmd_e;

endpackage

// File: rtl/wsched_hold_timer.sv
// Blocks reuse of a resource for HOLD cycles counted from the load cycle
// (load cycle included): busy is high for HOLD-1 cycles after a load.
module wsched_hold_timer #(
   parameter int HOLD = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);

   localparam int CW = ($clog2(HOLD) > 0) ? $clog2(HOLD) : 1;
   localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD - 1);

   if (HOLD < 1) begin : g_bad_hold
      $error("wsched_hold_timer: HOLD must be at least 1");
   end

   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load_i) begin
         left_q <= LOAD_VAL;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign busy_o = (left_q != '0);

   // R5 / R6: the owner never loads a timer that is still counting
   p_no_load_busy_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !load_i)
      else $error("p_no_load_busy_r5");

endmodule

// File: rtl/wsched_beat_pipe.sv
// Latency line for accepted writes. One bit enters per accept and walks a
// shift register. Fixed taps on it give the data-request window, the local
// word capture window and the memory data-valid window.
module wsched_beat_pipe #(
   parameter int TWL    = 5,
   parameter int NWORDS = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              wdata_req_o,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dv_o
);

   // stage_q[k] is high in cycle a+1+k for a write accepted in cycle a
   localparam int LEN    = TWL - 1 + NWORDS;
   localparam int REQ_AT = TWL - 3;   // strobe starts at a+TWL-2
   localparam int CAP_AT = TWL - 2;   // local word present at a+TWL-1
   localparam int DV_AT  = TWL - 1;   // memory data at a+TWL

   if (TWL < 3) begin : g_bad_twl
      $error("wsched_beat_pipe: TWL must be at least 3");
   end
   if (NWORDS < 1) begin : g_bad_nwords
      $error("wsched_beat_pipe: NWORDS must be at least 1");
   end

   logic [LEN-1:0]    stage_q;
   logic [DATA_W-1:0] dq_q;
   logic              cap_win;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else begin
         stage_q <= {stage_q[LEN-2:0], launch_i};
      end
   end

   assign wdata_req_o = |stage_q[REQ_AT +: NWORDS];
   assign cap_win     = |stage_q[CAP_AT +: NWORDS];
   assign mem_dv_o    = |stage_q[DV_AT  +: NWORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dq_q <= '0;
      end else begin
         dq_q <= cap_win ? wdata_i : '0;
      end
   end

   assign mem_dq_o = dq_q;

   // R3: every strobe cycle is followed two cycles later by a data cycle
   p_req_to_dv_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      wdata_req_o |-> ##2 mem_dv_o)
      else $error("p_req_to_dv_r3");

   // R3: no data cycle without a strobe two cycles earlier
   p_dv_from_req_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_dv_o |-> $past(wdata_req_o, 2))
      else $error("p_dv_from_req_r3");

   // R4: the bus is quiet outside data cycles
   p_dq_zero_idle_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !mem_dv_o |-> (mem_dq_o == '0))
      else $error("p_dq_zero_idle_r4");

endmodule

// File: rtl/wr_sched.sv
module wr_sched
   import wsched_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int BANK_W         = 3,
   parameter int DATA_W         = 32,
   parameter int BURST_LEN      = 8,
   parameter int BEATS_PER_WORD = 2,
   parameter int TWL            = 5,
   parameter int TRC            = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req_i,
   input  logic [BANK_W-1:0] wr_bank_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              wr_rdy_o,
   output logic [1:0]        mem_cmd_o,
   output logic [BANK_W-1:0] mem_bank_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              wdata_req_o,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dv_o
);

   localparam int NBANK  = 1 << BANK_W;
   localparam int NWORDS = BURST_LEN / BEATS_PER_WORD;

   if (BEATS_PER_WORD < 1 || (BURST_LEN % BEATS_PER_WORD) != 0) begin : g_bad_burst
      $error("wr_sched: BURST_LEN must be a multiple of BEATS_PER_WORD");
   end
   if (TRC < 2) begin : g_bad_trc
      $error("wr_sched: TRC must be at least 2");
   end
   if (TWL < 3) begin : g_bad_twl
      $error("wr_sched: TWL must be at least 3");
   end

   logic [NBANK-1:0] bank_busy;
   logic             bus_busy;
   logic             accept;

   // One row-cycle timer per bank
   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic bank_load;
      assign bank_load = accept && (wr_bank_i == BANK_W'(b));
      wsched_hold_timer #(.HOLD(TRC)) u_trc (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_i (bank_load),
         .busy_o (bank_busy[b])
      );
   end

   // Shared data-bus spacing timer
   wsched_hold_timer #(.HOLD(NWORDS)) u_bus_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .busy_o (bus_busy)
   );

   assign wr_rdy_o   = rst_n && !bank_busy[wr_bank_i] && !bus_busy;
   assign accept     = wr_req_i && wr_rdy_o;
   assign mem_cmd_o  = accept ? CMD_WRITE : CMD_NOP;
   assign mem_bank_o = wr_bank_i;
   assign mem_addr_o = wr_addr_i;

   wsched_beat_pipe #(
      .TWL    (TWL),
      .NWORDS (NWORDS),
      .DATA_W (DATA_W)
   ) u_pipe (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch_i    (accept),
      .wdata_i     (wdata_i),
      .wdata_req_o (wdata_req_o),
      .mem_dq_o    (mem_dq_o),
      .mem_dv_o    (mem_dv_o)
   );

   // R5: the bank just written is refused on the following cycle
   p_bank_block_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_o == CMD_WRITE) |=> ((wr_bank_i != $past(mem_bank_o)) || !wr_rdy_o))
      else $error("p_bank_block_r5");

   // R1: a write command carries the bank presented that cycle
   p_cmd_bank_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_o == CMD_WRITE) |-> (wr_req_i && (mem_bank_o == wr_bank_i)))
      else $error("p_cmd_bank_r1");

endmodule

// File: tb/wr_sched_bench.sv
module wr_sched_bench;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 16;
   localparam int BANK_W = 3;
   localparam int DATA_W = 32;
   localparam int BL     = 8;
   localparam int BPW    = 2;
   localparam int TWL    = 5;
   localparam int TRC    = 6;
   localparam int NW     = BL / BPW;
   localparam int NVEC   = 12;
   localparam int MAXW   = 64;

   // {idle[3:0], expect_accept, bank[2:0], addr[7:0]}
   localparam logic [15:0] VEC [NVEC] = '{
      16'h2810, 16'h3921, 16'h0132, 16'h2143, 16'h1954, 16'h2265,
      16'h0A76, 16'h3E87, 16'h3698, 16'h0BA9, 16'h3FBA, 16'h5FCB
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_req = 1'b0;
   logic [BANK_W-1:0] wr_bank = '0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic              wr_rdy;
   logic [1:0]        mem_cmd;
   logic [BANK_W-1:0] mem_bank;
   logic [ADDR_W-1:0] mem_addr;
   logic              wdata_req;
   logic [DATA_W-1:0] mem_dq;
   logic              mem_dv;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int n_acc = 0;
   int dv_seen = 0;
   int acc_cyc [MAXW];
   int acc_bank [MAXW];
   bit done = 1'b0;
   bit last_rdy;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wr_sched #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .BURST_LEN(BL),
      .BEATS_PER_WORD(BPW), .TWL(TWL), .TRC(TRC)
   ) u_wr_sched (
      .clk(clk), .rst_n(rst_n), .wr_req_i(wr_req), .wr_bank_i(wr_bank),
      .wr_addr_i(wr_addr), .wdata_i(wdata), .wr_rdy_o(wr_rdy),
      .mem_cmd_o(mem_cmd), .mem_bank_o(mem_bank), .mem_addr_o(mem_addr),
      .wdata_req_o(wdata_req), .mem_dq_o(mem_dq), .mem_dv_o(mem_dv)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic bit model_rdy(input int c, input int b);
      for (int i = 0; i < n_acc; i++) begin
         if (c - acc_cyc[i] < NW) return 1'b0;
         if (acc_bank[i] == b && c - acc_cyc[i] < TRC) return 1'b0;
      end
      return 1'b1;
   endfunction

   // index of the write whose strobe window holds cycle c, else -1
   function automatic int req_owner(input int c);
      for (int i = 0; i < n_acc; i++)
         if (c >= acc_cyc[i] + TWL - 2 && c < acc_cyc[i] + TWL - 2 + NW) return i;
      return -1;
   endfunction

   function automatic int dv_owner(input int c);
      for (int i = 0; i < n_acc; i++)
         if (c >= acc_cyc[i] + TWL && c < acc_cyc[i] + TWL + NW) return i;
      return -1;
   endfunction

   function automatic logic [DATA_W-1:0] data_word(input int i, input int w);
      return {16'(i + 1), 8'h5A, 8'(w)};
   endfunction

   // one cycle: called just after a rising edge
   task automatic run_cycle(input bit req, input int bank, input int addr);
      int ro;
      int dvo;
      bit exp_rdy;
      bit exp_cmd;
      logic [DATA_W-1:0] exp_dq;
      ro = req_owner(cyc - 1);
      wr_req  <= req;
      wr_bank <= BANK_W'(bank);
      wr_addr <= ADDR_W'(addr);
      wdata   <= (ro >= 0) ? data_word(ro, cyc - 1 - (acc_cyc[ro] + TWL - 2)) : '0;
      @(negedge clk);
      exp_rdy = model_rdy(cyc, bank);
      last_rdy = wr_rdy;
      check(wr_rdy == exp_rdy, "R5 R6 ready", wr_rdy, exp_rdy);
      exp_cmd = req && exp_rdy;
      check(mem_cmd == {1'b0, exp_cmd}, "R1 R9 command", mem_cmd, exp_cmd);
      if (exp_cmd) begin
         check(mem_bank == BANK_W'(bank), "R1 bank", mem_bank, bank);
         check(mem_addr == ADDR_W'(addr), "R1 addr", mem_addr, addr);
      end
      ro = req_owner(cyc);
      check(wdata_req == (ro >= 0), "R2 R7 wdata_req", wdata_req, ro >= 0);
      dvo = dv_owner(cyc);
      exp_dq = (dvo >= 0) ? data_word(dvo, cyc - acc_cyc[dvo] - TWL) : '0;
      check(mem_dv == (dvo >= 0), "R3 R4 mem_dv", mem_dv, dvo >= 0);
      check(mem_dq == exp_dq, "R3 R7 mem_dq", mem_dq, exp_dq);
      if (mem_dv) dv_seen++;
      if (exp_cmd && n_acc < MAXW) begin
         acc_cyc[n_acc]  = cyc;
         acc_bank[n_acc] = bank;
         n_acc++;
      end
      @(posedge clk);
      cyc++;
   endtask

   initial begin
      int cur_bank;
      int cur_addr;
      cur_bank = 0;
      cur_addr = 0;
      // R8: reset state
      repeat (3) @(posedge clk);
      wr_req <= 1'b1;
      @(negedge clk);
      check(wr_rdy == 1'b0, "R8 ready in reset", wr_rdy, 0);
      check(mem_cmd == 2'b00, "R8 command in reset", mem_cmd, 0);
      check(wdata_req == 1'b0, "R8 wdata_req in reset", wdata_req, 0);
      check(mem_dv == 1'b0, "R8 mem_dv in reset", mem_dv, 0);
      check(mem_dq == '0, "R8 mem_dq in reset", mem_dq, 0);
      @(posedge clk);
      wr_req <= 1'b0;
      rst_n  <= 1'b1;

      // first cycle after release: ready must be high (R8)
      run_cycle(1'b0, 0, 0);
      check(last_rdy == 1'b1, "R8 ready after release", last_rdy, 1);

      // table walk
      for (int v = 0; v < NVEC; v++) begin
         for (int k = 0; k < int'(VEC[v][15:12]); k++)
            run_cycle(1'b0, cur_bank, cur_addr);
         cur_bank = int'(VEC[v][10:8]);
         cur_addr = int'(VEC[v][7:0]);
         run_cycle(1'b1, cur_bank, cur_addr);
         check(last_rdy == VEC[v][11], "R5 R6 R9 table accept", last_rdy, VEC[v][11]);
      end
      repeat (TWL + NW + 3) run_cycle(1'b0, cur_bank, cur_addr);

      // directed: a request held high through the busy time (R9, R5)
      run_cycle(1'b1, 4, 16'h0444);
      for (int k = 0; k < TRC - 1; k++) begin
         run_cycle(1'b1, 4, 16'h0445);
         check(last_rdy == 1'b0, "R5 R9 held same bank", last_rdy, 0);
      end
      run_cycle(1'b1, 4, 16'h0446);
      check(last_rdy == 1'b1, "R5 held same bank at TRC", last_rdy, 1);
      repeat (TWL + NW + 3) run_cycle(1'b0, 4, 0);

      // R4: total data cycles equal NW per accepted write
      check(dv_seen == n_acc * NW, "R4 data cycle count", dv_seen, n_acc * NW);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule